// File: doc/BRIEF.md
# Serial Peripheral Byte Shifter with Flag Logic

This block moves one byte at a time over a four-wire serial link, either generating the serial clock itself (master) or following a clock from outside (slave). A local CPU reaches it through three byte-wide registers: control, status and data. A write to the data register while the block is idle loads the byte to send. In master mode that write also starts the transfer. The received byte is read back from the same address.

In master mode the serial clock is divided down from the system clock. The divisor comes from a double-speed bit in the status register together with two rate bits in the control register. Clock polarity, clock phase and bit order are set by control bits. Two sticky flags report what happened: one marks a completed transfer, the other marks a data write that arrived while a transfer was running. Both flags are cleared by reading the status register while a flag is set and then accessing the data register. The completion flag also clears when the interrupt vector is acknowledged. In master mode, a low level on the slave-select input is treated as a fault and sets the completion flag.

Top module: `spi_xfer_engine`

## Requirements
- R1: With the enable bit (control bit 6) and the master bit (control bit 4) set, a write to the data register (address 2) while idle shifts out 8 bits and shifts in 8 bits. At the end, the completion flag is set and a read of address 2 returns the received byte.
- R2: `irq_o` is 1 exactly when the completion flag, the interrupt enable (control bit 7) and `gie_i` are all 1.
- R3: In enabled master mode, a low `ss_n_i` sets the completion flag within five clock cycles.
- R4: A status read (address 1) that sees either flag set arms a clearing latch. The next read or write of address 2 then clears both flags. An access to address 2 without that prior status read leaves the flags unchanged. A one-cycle pulse on `irq_ack_i` clears the completion flag.
- R5: A write to address 2 during a transfer sets the collision flag. The written byte is discarded and the running transfer is not disturbed. If a clearing access and a new collision happen in the same cycle, the collision flag stays set.
- R6: Status reads as {completion, collision, five zeros, double-speed}, with bit 7 as the MSB. Only bit 0 is writable.
- R7: In master mode the SCK period, in system clocks, is selected by {double-speed, control bit 1, control bit 0}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R8: When idle, SCK rests at the polarity bit (control bit 3). With the phase bit (control bit 2) at 0, data is sampled on the first edge of each bit. With it at 1, data is sampled on the second edge.
- R9: Control bit 5 at 1 sends and receives LSB first. At 0 the order is MSB first.
- R10: In enabled slave mode, SCK, slave-select and MOSI are synchronised through two flops. With `ss_n_i` low, 16 SCK edges receive one byte from `mosi_i` and send the preloaded byte on `miso_o`, then set the completion flag.
- R11: After reset the control and status registers read 0, `irq_o` is 0 and `sck_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt vector acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The flag logic can be asked to clear the collision flag and to set it again in the same cycle. This happens when a second colliding data write follows a status read that armed the clearing latch. The bench provokes it during a slow transfer: it collides once, reads status to arm the latch, then collides again. It expects status to show the collision flag set and the completion flag clear. Once that transfer ends, it expects both flags to be set, and the received byte to come from the first write only.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } spi_ctrl_t;

    // Half of the SCK period in system clocks for {double, rate}
    function automatic int unsigned half_period(input logic [2:0] sel);
        int unsigned base;
        case (sel[1:0])
            2'b00:   base = 2;
            2'b01:   base = 8;
            2'b10:   base = 32;
            default: base = 64;
        endcase
        if (sel[2]) begin
            base = (sel[1:0] == 2'b11) ? 32 : base / 2;
        end
        return base;
    endfunction

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_xfer_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t        div_d, div_q;
    int unsigned half;

    always_comb begin
        div_d  = div_q;
        tick_o = 1'b0;
        half   = half_period(sel_i);
        if (restart_i || !run_i) begin
            div_d.cnt = '0;
        end else if (div_q.cnt == CNT_W'(half - 1)) begin
            div_d.cnt = '0;
            tick_o    = 1'b1;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R7: ticks are spaced by the half period, never back to back unless half is one
    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || half == 1));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          master_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          lsb_i,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_byte_i,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          miso_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          ss_low_o
);

    localparam int EDGES = 2 * DW;
    localparam int CNT_W = $clog2(EDGES);
    localparam int LAST  = EDGES - 1;

    typedef struct packed {
        logic [DW-1:0]    sreg;
        logic [DW-1:0]    rx_byte;
        logic [CNT_W-1:0] cnt;
        logic             rx_bit;
        logic             active;
        logic             sck_lvl;
        logic             done;
        logic             sck_m;
        logic             sck_s;
        logic             sck_p;
        logic             ss_m;
        logic             ss_s;
        logic             mo_m;
        logic             mo_s;
    } core_t;

    core_t         core_d, core_q;
    logic          in_bit, edge_ev, smp, last;
    logic [DW-1:0] nxt;

    function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] s, input logic b,
                                               input logic lsb);
        return lsb ? {b, s[DW-1:1]} : {s[DW-2:0], b};
    endfunction

    always_comb begin
        core_d       = core_q;
        core_d.done  = 1'b0;
        core_d.sck_m = sck_i;
        core_d.sck_s = core_q.sck_m;
        core_d.sck_p = core_q.sck_s;
        core_d.ss_m  = ss_n_i;
        core_d.ss_s  = core_q.ss_m;
        core_d.mo_m  = mosi_i;
        core_d.mo_s  = core_q.mo_m;

        in_bit  = master_i ? miso_i : core_q.mo_s;
        edge_ev = master_i ? (core_q.active & tick_i)
                           : (enable_i & ~core_q.ss_s & (core_q.sck_s ^ core_q.sck_p));
        smp     = (core_q.cnt[0] == cpha_i);
        last    = (core_q.cnt == CNT_W'(LAST));

        nxt = core_q.sreg;
        if (!cpha_i) begin
            if (!smp) nxt = shift_in(core_q.sreg, core_q.rx_bit, lsb_i);
        end else if (smp) begin
            if (last) nxt = shift_in(core_q.sreg, in_bit, lsb_i);
        end else if (core_q.cnt != '0) begin
            nxt = shift_in(core_q.sreg, core_q.rx_bit, lsb_i);
        end

        if (load_i) begin
            core_d.sreg    = load_byte_i;
            core_d.cnt     = '0;
            core_d.active  = master_i;
            core_d.sck_lvl = 1'b0;
        end else if (!master_i && (core_q.ss_s || !enable_i)) begin
            core_d.cnt = '0;
        end else if (edge_ev) begin
            if (master_i) core_d.sck_lvl = ~core_q.sck_lvl;
            if (smp && !last) core_d.rx_bit = in_bit;
            if (last) begin
                core_d.done    = 1'b1;
                core_d.cnt     = '0;
                core_d.active  = 1'b0;
                core_d.rx_byte = nxt;
            end else begin
                core_d.cnt  = core_q.cnt + 1'b1;
                core_d.sreg = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.ss_m <= 1'b1;
            core_q.ss_s <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign sck_o     = cpol_i ^ core_q.sck_lvl;
    assign mosi_o    = lsb_i ? core_q.sreg[0] : core_q.sreg[DW-1];
    assign miso_o    = mosi_o;
    assign busy_o    = master_i ? core_q.active : (core_q.cnt != '0);
    assign done_o    = core_q.done;
    assign rx_byte_o = core_q.rx_byte;
    assign ss_low_o  = ~core_q.ss_s;

    // R8: an idle master holds SCK at the polarity level
    assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !core_q.active) |-> (sck_o == cpol_i));

    // R1: completion is only reported at the end of a running transfer
    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.done |-> $past(busy_o));

endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic fault_i,
    input  logic collide_i,
    input  logic stat_rd_i,
    input  logic data_acc_i,
    input  logic ack_i,
    output logic spif_o,
    output logic wcol_o
);

    typedef struct packed {
        logic spif;
        logic wcol;
        logic arm;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (stat_rd_i && (flag_q.spif || flag_q.wcol)) flag_d.arm = 1'b1;
        if (data_acc_i && flag_q.arm) begin
            flag_d.spif = 1'b0;
            flag_d.wcol = 1'b0;
            flag_d.arm  = 1'b0;
        end
        if (ack_i) flag_d.spif = 1'b0;
        if (done_i || fault_i) flag_d.spif = 1'b1;
        if (collide_i) flag_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign spif_o = flag_q.spif;
    assign wcol_o = flag_q.wcol;

    // R4: the completion flag falls only through acknowledge or an armed data access
    assert_spif_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q.spif) |-> $past(ack_i || (data_acc_i && flag_q.arm)));

    // R4: the latch arms only on a status read that saw a flag
    assert_arm_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q.arm) |-> $past(stat_rd_i && (flag_q.spif || flag_q.wcol)));

    // R5: the collision flag rises only after a colliding write
    assert_wcol_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q.wcol) |-> $past(collide_i));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DW        = 8,
    parameter int ADDR_W    = 2,
    parameter int DIV_CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              gie_i,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic              sck_o,
    input  logic              sck_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i,
    input  logic              ss_n_i
);

    typedef struct packed {
        spi_ctrl_t ctrl;
        logic      dbl;
    } regs_t;

    regs_t         regs_d, regs_q;
    logic          sel_ctrl, sel_stat, sel_data;
    logic          data_wr, data_acc, stat_rd;
    logic          busy, done, tick, ss_low, load, collide, fault;
    logic          spif, wcol;
    logic [DW-1:0] rx_byte;

    assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(ADDR_STAT));
    assign sel_data = (bus_addr == ADDR_W'(ADDR_DATA));
    assign data_wr  = bus_wr & sel_data;
    assign data_acc = (bus_wr | bus_rd) & sel_data;
    assign stat_rd  = bus_rd & sel_stat;
    assign load     = data_wr & regs_q.ctrl.enable & ~busy;
    assign collide  = data_wr & busy;
    assign fault    = regs_q.ctrl.enable & regs_q.ctrl.master & ss_low;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr && sel_ctrl) regs_d.ctrl = spi_ctrl_t'(bus_wdata[REG_W-1:0]);
        if (bus_wr && sel_stat) regs_d.dbl  = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[REG_W-1:0] = regs_q.ctrl;
        end else if (sel_stat) begin
            bus_rdata[DW-1] = spif;
            bus_rdata[DW-2] = wcol;
            bus_rdata[0]    = regs_q.dbl;
        end else if (sel_data) begin
            bus_rdata = rx_byte;
        end
    end

    assign irq_o = spif & regs_q.ctrl.irq_en & gie_i;

    spi_rate_div #(.CNT_W(DIV_CNT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .run_i     (regs_q.ctrl.master & busy),
        .sel_i     ({regs_q.dbl, regs_q.ctrl.rate}),
        .tick_o    (tick)
    );

    spi_shift_core #(.DW(DW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (regs_q.ctrl.enable),
        .master_i    (regs_q.ctrl.master),
        .cpol_i      (regs_q.ctrl.cpol),
        .cpha_i      (regs_q.ctrl.cpha),
        .lsb_i       (regs_q.ctrl.lsb_first),
        .tick_i      (tick),
        .load_i      (load),
        .load_byte_i (bus_wdata),
        .sck_i       (sck_i),
        .ss_n_i      (ss_n_i),
        .mosi_i      (mosi_i),
        .miso_i      (miso_i),
        .sck_o       (sck_o),
        .mosi_o      (mosi_o),
        .miso_o      (miso_o),
        .busy_o      (busy),
        .done_o      (done),
        .rx_byte_o   (rx_byte),
        .ss_low_o    (ss_low)
    );

    spi_status_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .fault_i    (fault),
        .collide_i  (collide),
        .stat_rd_i  (stat_rd),
        .data_acc_i (data_acc),
        .ack_i      (irq_ack_i),
        .spif_o     (spif),
        .wcol_o     (wcol)
    );

endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gie_i = 1'b1, irq_ack_i = 1'b0, irq_o;
    logic       sck_o, sck_i = 1'b0, mosi_o, mosi_i = 1'b0, miso_o, miso_i;
    logic       ss_n_i = 1'b1;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // bench-side slave model for master transfers
    logic       m_on = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic [7:0] m_tx = 8'h00, m_rx = 8'h00;
    int         m_e = 0, m_idx = 0, m_rise = 0;
    longint     t0 = 0, t1 = 0;

    always #5 clk = ~clk;

    spi_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie_i(gie_i), .irq_ack_i(irq_ack_i),
        .irq_o(irq_o), .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    function automatic int bpos(input logic lsb, input int k);
        return lsb ? k : 7 - k;
    endfunction

    function automatic int divisor(input logic [2:0] sel);
        case (sel)
            3'b000: return 4;   3'b001: return 16;
            3'b010: return 64;  3'b011: return 128;
            3'b100: return 2;   3'b101: return 8;
            3'b110: return 32;  default: return 64;
        endcase
    endfunction

    function automatic logic [7:0] stat_val(input logic f, input logic w, input logic d);
        return {f, w, 5'b00000, d};
    endfunction

    assign miso_i = m_tx[bpos(m_lsb, (m_idx > 7) ? 7 : m_idx)];

    always @(sck_o) begin
        if (m_on) begin
            if (sck_o === 1'b1) begin
                if (m_rise == 0) t0 = $time;
                else if (m_rise == 1) t1 = $time;
                m_rise++;
            end
            if ((m_e % 2) == int'(m_cpha)) m_rx[bpos(m_lsb, m_e / 2)] = mosi_o;
            else if (!(m_cpha && m_e == 0)) m_idx++;
            m_e++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    task automatic setup_master(input logic cpol, input logic cpha, input logic lsb,
                                input logic [2:0] sel, input logic [7:0] t);
        bus_write(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, sel[1:0]});
        bus_write(2'd1, {7'd0, sel[2]});
        m_tx = t; m_lsb = lsb; m_cpha = cpha; m_rx = 8'h00;
        m_e = 0; m_idx = 0; m_rise = 0; m_on = 1'b1;
    endtask

    task automatic master_xfer(input logic [7:0] w, input logic [7:0] t, input logic cpol,
                               input logic cpha, input logic lsb, input logic [2:0] sel);
        logic [7:0] v;
        setup_master(cpol, cpha, lsb, sel, t);
        chk("R8 idle sck before", sck_o, cpol);
        bus_write(2'd2, w);
        wait_irq();
        m_on = 1'b0;
        chk("R1 irq after transfer", irq_o, 1'b1);
        bus_read(2'd2, v);
        chk("R1 R9 master received byte", v, t);
        chk("R1 R9 slave model received byte", m_rx, w);
        chk("R7 sck period", 32'((t1 - t0) / 10), divisor(sel));
        chk("R8 idle sck after", sck_o, cpol);
        bus_read(2'd1, v);
        chk("R6 status after transfer", v, stat_val(1'b1, 1'b0, sel[2]));
        bus_read(2'd2, v);
        chk("R4 flags cleared by sequence", irq_o, 1'b0);
    endtask

    initial begin
        logic [7:0] v, cap;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_read(2'd0, v);
        chk("R11 ctrl after reset", v, 8'h00);
        bus_read(2'd1, v);
        chk("R11 status after reset", v, 8'h00);
        chk("R11 irq after reset", irq_o, 1'b0);
        chk("R11 sck after reset", sck_o, 1'b0);

        // R6 only bit 0 of status is writable
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, v);
        chk("R6 status write mask", v, 8'h01);
        bus_write(2'd1, 8'h00);

        // R7 every rate setting, mode 0, MSB first
        for (int s = 0; s < 8; s++) master_xfer(8'hA5 ^ 8'(s), 8'h3C + 8'(s), 1'b0, 1'b0, 1'b0, 3'(s));

        // R8 R9 directed modes and bit order
        master_xfer(8'h81, 8'h7E, 1'b1, 1'b0, 1'b0, 3'b100);
        master_xfer(8'h01, 8'hF0, 1'b0, 1'b1, 1'b1, 3'b000);
        master_xfer(8'hC3, 8'h18, 1'b1, 1'b1, 1'b1, 3'b101);

        // random mix of modes, order and rates
        for (int i = 0; i < 20; i++) begin
            logic [2:0] rs = 3'($urandom % 8);
            master_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rs);
        end

        // R2 interrupt gating and R4 access without arming
        setup_master(1'b0, 1'b0, 1'b0, 3'b100, 8'h55);
        bus_write(2'd2, 8'h99);
        wait_irq();
        m_on = 1'b0;
        bus_read(2'd2, v);
        chk("R4 unarmed data read keeps flag", irq_o, 1'b1);
        gie_i = 1'b0;
        #1 chk("R2 irq masked by global enable", irq_o, 1'b0);
        gie_i = 1'b1;
        bus_write(2'd0, 8'h50);
        #1 chk("R2 irq masked by control enable", irq_o, 1'b0);
        bus_write(2'd0, 8'hD0);
        #1 chk("R2 irq with both enables", irq_o, 1'b1);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        chk("R4 armed data read clears", irq_o, 1'b0);

        // R4 clear by vector acknowledge
        setup_master(1'b0, 1'b0, 1'b0, 3'b000, 8'h12);
        bus_write(2'd2, 8'h34);
        wait_irq();
        m_on = 1'b0;
        @(negedge clk); irq_ack_i = 1'b1;
        @(negedge clk); irq_ack_i = 1'b0;
        #1 chk("R4 acknowledge clears completion", irq_o, 1'b0);
        bus_read(2'd1, v);
        chk("R4 status after acknowledge", v, 8'h00);

        // R5 collisions, including clear and set in one cycle
        setup_master(1'b0, 1'b0, 1'b0, 3'b011, 8'h6B);
        bus_write(2'd2, 8'hE7);
        repeat (5) @(negedge clk);
        bus_write(2'd2, 8'h11);
        bus_read(2'd1, v);
        chk("R5 collision flag set", v, 8'h40);
        bus_write(2'd2, 8'h22);
        bus_read(2'd1, v);
        chk("R5 collision survives same-cycle clear", v, 8'h40);
        wait_irq();
        m_on = 1'b0;
        bus_read(2'd1, v);
        chk("R5 both flags after transfer", v, 8'hC0);
        chk("R5 collided bytes discarded", m_rx, 8'hE7);
        bus_read(2'd2, v);
        chk("R5 transfer undisturbed", v, 8'h6B);
        bus_read(2'd1, v);
        chk("R5 both flags cleared", v, 8'h00);

        // R3 slave-select fault in master mode
        bus_write(2'd0, 8'hD0);
        @(negedge clk); ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 fault sets completion", irq_o, 1'b1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2'd1, v);
        bus_read(2'd2, v);
        bus_read(2'd1, v);
        chk("R3 fault flag cleared", v, 8'h00);

        // R10 slave mode 0, MSB first
        bus_write(2'd0, 8'hC0);
        bus_write(2'd2, 8'hB4);
        cap = 8'h00;
        mosi_i = 1'b0; // bit 7 of 8'h5A
        ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            cap[7 - k] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            if (k < 7) mosi_i = 8'h5A >> (6 - k);
            repeat (8) @(negedge clk);
        end
        ss_n_i = 1'b1;
        chk("R10 slave completion", irq_o, 1'b1);
        chk("R10 slave sent byte", cap, 8'hB4);
        bus_read(2'd2, v);
        chk("R10 slave received byte", v, 8'h5A);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule